// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block produces the column address for every beat of a read or write burst in an SDRAM model or controller. A command strobe loads a starting column, a burst length code and a wrap type. The block then presents one column per clock, together with a beat-valid flag, until the burst completes. A burst can also end early through a stop strobe or be replaced by a new command.

Two beat orderings are available. In sequential ordering, the low column bits count upward and wrap inside the burst-length window. In interleaved ordering, the low column bits are the starting bits XORed with the beat index. In both orderings the column bits above the window never change.

A full-page length runs through all 256 columns and keeps wrapping until a stop or a new command arrives. Full page is defined for sequential ordering only. If full page is requested together with interleave, the block raises a flag and runs the burst in sequential order. A stop ends the current burst and leaves nothing else to clean up, so the open row stays usable for the next access.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, `beat_vld`, `beat_wr`, `burst_done` and `mode_err` are all 0.
- R2: The length code `len_sel` selects 1, 2, 4 or 8 beats for the values 0, 1, 2 and 3. A burst started by `cmd_go` on an idle clock shows beat 0 in the next cycle and gives exactly that many consecutive valid beats. In the cycle after the last beat, `beat_vld` is 0 and `burst_done` is 1.
- R3: With `wrap_il`=0 and BL=2^n, beat k has column `(start & ~(BL-1)) | ((start + k) & (BL-1))`.
- R4: With `wrap_il`=1 and BL=2^n, beat k has column `(start & ~(BL-1)) | ((start ^ k) & (BL-1))`.
- R5: A `len_sel` value of 4 or greater selects full page. Beat k then has column `(start + k) mod 256`, and the burst keeps running beyond 256 beats until it is stopped or interrupted.
- R6: If full page is requested with `wrap_il`=1, `mode_err` is 1 on every beat of that burst and the beats follow the R5 sequential order. `mode_err` is 0 whenever `beat_vld` is 0.
- R7: `cmd_go` is ignored while a burst is running. The running burst keeps its columns and its length.
- R8: `cmd_intr` starts a new burst on any clock, from its own `start_col`, length and ordering. The new beat 0 appears in the next cycle. If a burst was running, `burst_done` is 1 in that same cycle.
- R9: `burst_stop` registered while a beat is shown ends the burst. In the next cycle `beat_vld` is 0 and `burst_done` is 1.
- R10: `beat_wr` is 1 exactly on valid beats of a burst started with `cmd_write`=1. No write beat follows a stop.
- R11: `burst_done` lasts one cycle when it is not followed at once by the end of another burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_go | input | 1 | Start a burst when idle |
| cmd_intr | input | 1 | Start a burst now, replacing any running one |
| burst_stop | input | 1 | End the running burst early |
| cmd_write | input | 1 | The burst being started is a write |
| wrap_il | input | 1 | 1 = interleaved order, 0 = sequential |
| len_sel | input | 3 | Length code: 0..3 give 1/2/4/8 beats, 4..7 give full page |
| start_col | input | 8 | Starting column of the burst |
| beat_col | output | 8 | Column of the current beat |
| beat_vld | output | 1 | A beat is presented this cycle |
| beat_wr | output | 1 | The current beat is a write beat |
| burst_done | output | 1 | A burst ended at the previous edge |
| mode_err | output | 1 | Current burst requested full page with interleave |

## Verification
The case that is hardest to reach is a full-page burst that runs past column 255 and back to its own start. It takes more than 256 consecutive beats with no stop and no new command, which random short bursts almost never produce. Directed full-page bursts of 300 beats cover this, and the random bursts choose a stop point anywhere in that range. The random stimulus mixes every length code, including the illegal full-page-with-interleave request. Directed cases place `cmd_go` and `cmd_intr` in the middle of a running burst.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    typedef enum logic {
        WRAP_SEQ = 1'b0,
        WRAP_IL  = 1'b1
    } wrap_e;

endpackage

// File: rtl/bcs_len_decode.sv
module bcs_len_decode #(
    parameter int COL_W    = 8,
    parameter int LEN_W    = 3,
    parameter int MAX_LOG2 = 3
) (
    input  logic [LEN_W-1:0] len_sel,
    input  logic             il_req,
    output logic [COL_W-1:0] win_mask,
    output logic             full_pg,
    output logic             il_eff,
    output logic             bad_combo
);
    import bcs_pkg::*;

    // Length codes above MAX_LOG2 select a full page (R5).
    assign full_pg = (int'(len_sel) > MAX_LOG2);

    // Full page with interleave is flagged and run as sequential (R6).
    assign bad_combo = full_pg && (il_req == WRAP_IL);
    assign il_eff    = il_req && !full_pg;

    for (genvar i = 0; i < COL_W; i++) begin : g_mask
        assign win_mask[i] = full_pg || (i < int'(len_sel));
    end

endmodule

// File: rtl/bcs_col_gen.sv
module bcs_col_gen #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] idx,
    input  logic [COL_W-1:0] win_mask,
    input  logic             il,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] seq_sum;

    // Carries out of the window are dropped by the mask (R3).
    assign seq_sum = base + idx;

    for (genvar i = 0; i < COL_W; i++) begin : g_bit
        // Bits inside the window take the beat order (R3 sequential, R4 XOR).
        // Bits above the window keep the starting value.
        assign col[i] = win_mask[i] ? (il ? (base[i] ^ idx[i]) : seq_sum[i])
                                    : base[i];
    end

endmodule

// File: rtl/bcs_ctrl.sv
module bcs_ctrl #(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             intr,
    input  logic             stop,
    input  logic             wr_req,
    input  logic [COL_W-1:0] start_col,
    input  logic [COL_W-1:0] dec_mask,
    input  logic             dec_full,
    input  logic             dec_il,
    input  logic             dec_err,
    output logic [COL_W-1:0] base_o,
    output logic [COL_W-1:0] idx_o,
    output logic [COL_W-1:0] mask_o,
    output logic             il_o,
    output logic             vld_o,
    output logic             wr_o,
    output logic             err_o,
    output logic             done_o
);
    typedef struct packed {
        logic             vld;
        logic             wr;
        logic             il;
        logic             full;
        logic             err;
        logic             done;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] idx;
        logic [COL_W-1:0] mask;
    } st_t;

    st_t st_d, st_q;
    logic last_beat;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        // Only finite bursts have a last beat (R2).
        // A full-page burst keeps wrapping (R5).
        last_beat = st_q.vld && !st_q.full && (st_q.idx == st_q.mask);

        if (intr) begin
            // An interrupting command restarts from its own column (R8).
            st_d.vld  = 1'b1;
            st_d.wr   = wr_req;
            st_d.il   = dec_il;
            st_d.full = dec_full;
            st_d.err  = dec_err;
            st_d.base = start_col;
            st_d.idx  = '0;
            st_d.mask = dec_mask;
            st_d.done = st_q.vld;
        end else if (st_q.vld) begin
            // While a burst runs, cmd_go has no effect (R7).
            if (stop || last_beat) begin
                // Burst ends; no later write beat is issued (R9, R10).
                st_d.vld  = 1'b0;
                st_d.wr   = 1'b0;
                st_d.err  = 1'b0;
                st_d.done = 1'b1;
            end else begin
                // The index wraps modulo 2^COL_W on a full page (R5).
                st_d.idx = st_q.idx + 1'b1;
            end
        end else if (go) begin
            st_d.vld  = 1'b1;
            st_d.wr   = wr_req;
            st_d.il   = dec_il;
            st_d.full = dec_full;
            st_d.err  = dec_err;
            st_d.base = start_col;
            st_d.idx  = '0;
            st_d.mask = dec_mask;
        end
    end

    // All state clears on reset (R1).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign base_o = st_q.base;
    assign idx_o  = st_q.idx;
    assign mask_o = st_q.mask;
    assign il_o   = st_q.il;
    assign vld_o  = st_q.vld;
    assign wr_o   = st_q.vld && st_q.wr;
    assign err_o  = st_q.vld && st_q.err;
    assign done_o = st_q.done;

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
    parameter int COL_W    = 8,
    parameter int LEN_W    = 3,
    parameter int MAX_LOG2 = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_go,
    input  logic             cmd_intr,
    input  logic             burst_stop,
    input  logic             cmd_write,
    input  logic             wrap_il,
    input  logic [LEN_W-1:0] len_sel,
    input  logic [COL_W-1:0] start_col,
    output logic [COL_W-1:0] beat_col,
    output logic             beat_vld,
    output logic             beat_wr,
    output logic             burst_done,
    output logic             mode_err
);
    logic [COL_W-1:0] dec_mask;
    logic             dec_full;
    logic             dec_il;
    logic             dec_err;
    logic [COL_W-1:0] cur_base;
    logic [COL_W-1:0] cur_idx;
    logic [COL_W-1:0] cur_mask;
    logic             cur_il;

    bcs_len_decode #(
        .COL_W    (COL_W),
        .LEN_W    (LEN_W),
        .MAX_LOG2 (MAX_LOG2)
    ) u_dec (
        .len_sel   (len_sel),
        .il_req    (wrap_il),
        .win_mask  (dec_mask),
        .full_pg   (dec_full),
        .il_eff    (dec_il),
        .bad_combo (dec_err)
    );

    bcs_ctrl #(
        .COL_W (COL_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (cmd_go),
        .intr      (cmd_intr),
        .stop      (burst_stop),
        .wr_req    (cmd_write),
        .start_col (start_col),
        .dec_mask  (dec_mask),
        .dec_full  (dec_full),
        .dec_il    (dec_il),
        .dec_err   (dec_err),
        .base_o    (cur_base),
        .idx_o     (cur_idx),
        .mask_o    (cur_mask),
        .il_o      (cur_il),
        .vld_o     (beat_vld),
        .wr_o      (beat_wr),
        .err_o     (mode_err),
        .done_o    (burst_done)
    );

    bcs_col_gen #(
        .COL_W (COL_W)
    ) u_col (
        .base     (cur_base),
        .idx      (cur_idx),
        .win_mask (cur_mask),
        .il       (cur_il),
        .col      (beat_col)
    );

endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
    parameter int COL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_go,
    input logic             cmd_intr,
    input logic             burst_stop,
    input logic [COL_W-1:0] start_col,
    input logic [COL_W-1:0] beat_col,
    input logic             beat_vld,
    input logic             beat_wr,
    input logic             burst_done,
    input logic             mode_err
);

    assert_idle_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!beat_vld && cmd_go && !cmd_intr) |=> (beat_vld && beat_col == $past(start_col)));

    assert_intr_col_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_intr |=> (beat_vld && beat_col == $past(start_col)));

    assert_stop_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_vld && burst_stop && !cmd_intr) |=> (!beat_vld && burst_done));

    assert_wr_in_beat_R10: assert property (@(posedge clk) disable iff (!rst_n)
        beat_wr |-> beat_vld);

    assert_err_in_beat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |-> beat_vld);

    assert_done_after_beat_R11: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |-> $past(beat_vld));

endmodule

bind burst_col_seq bcs_checker #(.COL_W(COL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_go     (cmd_go),
    .cmd_intr   (cmd_intr),
    .burst_stop (burst_stop),
    .start_col  (start_col),
    .beat_col   (beat_col),
    .beat_vld   (beat_vld),
    .beat_wr    (beat_wr),
    .burst_done (burst_done),
    .mode_err   (mode_err)
);

// File: tb/sim_burst_col_seq.sv
module sim_burst_col_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_go = 1'b0;
    logic       cmd_intr = 1'b0;
    logic       burst_stop = 1'b0;
    logic       cmd_write = 1'b0;
    logic       wrap_il = 1'b0;
    logic [2:0] len_sel = '0;
    logic [7:0] start_col = '0;
    logic [7:0] beat_col;
    logic       beat_vld;
    logic       beat_wr;
    logic       burst_done;
    logic       mode_err;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    burst_col_seq u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_go     (cmd_go),
        .cmd_intr   (cmd_intr),
        .burst_stop (burst_stop),
        .cmd_write  (cmd_write),
        .wrap_il    (wrap_il),
        .len_sel    (len_sel),
        .start_col  (start_col),
        .beat_col   (beat_col),
        .beat_vld   (beat_vld),
        .beat_wr    (beat_wr),
        .burst_done (burst_done),
        .mode_err   (mode_err)
    );

    function automatic int exp_col(int s, int l, bit il, int k);
        int m;
        int low;
        bit full = (l > 3);
        m = full ? 255 : ((1 << l) - 1);
        low = (il && !full) ? (s ^ k) : (s + k);
        return (s & ~m & 255) | (low & m);
    endfunction

    function automatic string mode_tag(int l, bit il);
        if (l > 3) return il ? "R6" : "R5";
        return il ? "R4" : "R3";
    endfunction

    task automatic chk(bit ok, string tag, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Checks one beat: R2 valid, R3/R4/R5/R6 column, R10 write, R6 flag.
    task automatic chk_beat(int s, int l, bit il, bit w, int k);
        bit e = (l > 3) && il;
        chk(beat_vld == 1'b1, "R2", int'(beat_vld), 1);
        chk(int'(beat_col) == exp_col(s, l, il, k), mode_tag(l, il),
            int'(beat_col), exp_col(s, l, il, k));
        chk(beat_wr == w, "R10", int'(beat_wr), int'(w));
        chk(mode_err == e, "R6", int'(mode_err), int'(e));
    endtask

    task automatic burst(int s, int l, bit il, bit w, int stop_at);
        int n = (l <= 3) ? (1 << l) : 1 << 30;
        @(negedge clk);
        cmd_go = 1'b1; start_col = 8'(s); len_sel = 3'(l); wrap_il = il; cmd_write = w;
        @(negedge clk);
        cmd_go = 1'b0;
        for (int k = 0; k < n; k++) begin
            chk_beat(s, l, il, w, k);
            if (k == stop_at) begin
                burst_stop = 1'b1;
                @(negedge clk);
                burst_stop = 1'b0;
                chk(beat_vld == 1'b0, "R9", int'(beat_vld), 0);
                chk(burst_done == 1'b1, "R9", int'(burst_done), 1);
                chk(beat_wr == 1'b0, "R10", int'(beat_wr), 0);
                break;
            end
            @(negedge clk);
            if (k == n - 1) begin
                chk(beat_vld == 1'b0, "R2", int'(beat_vld), 0);
                chk(burst_done == 1'b1, "R2", int'(burst_done), 1);
            end
        end
        @(negedge clk);
        chk(burst_done == 1'b0, "R11", int'(burst_done), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(beat_vld == 1'b0, "R1", int'(beat_vld), 0);
        chk(beat_wr == 1'b0, "R1", int'(beat_wr), 0);
        chk(burst_done == 1'b0, "R1", int'(burst_done), 0);
        chk(mode_err == 1'b0, "R1", int'(mode_err), 0);

        // Directed bursts of every length and both orderings.
        burst(8'h35, 0, 1'b0, 1'b0, -1);
        burst(8'h37, 1, 1'b1, 1'b1, -1);
        burst(8'h35, 2, 1'b0, 1'b0, -1);
        burst(8'h35, 3, 1'b1, 1'b1, -1);
        burst(8'hFE, 3, 1'b0, 1'b0, -1);
        // Full page that wraps past column 255 (R5), and the flagged combo (R6).
        burst(8'hF0, 7, 1'b0, 1'b1, 299);
        burst(8'h10, 4, 1'b1, 1'b0, 270);
        // Write stopped early (R9, R10).
        burst(8'h44, 3, 1'b0, 1'b1, 2);

        // R7: cmd_go during a running burst changes nothing.
        @(negedge clk);
        cmd_go = 1'b1; start_col = 8'h35; len_sel = 3'd3; wrap_il = 1'b0; cmd_write = 1'b0;
        @(negedge clk);
        cmd_go = 1'b0;
        for (int k = 0; k < 8; k++) begin
            chk(int'(beat_col) == exp_col(8'h35, 3, 1'b0, k), "R7", int'(beat_col),
                exp_col(8'h35, 3, 1'b0, k));
            if (k == 2) begin
                cmd_go = 1'b1; start_col = 8'hA0; len_sel = 3'd0; wrap_il = 1'b1;
            end
            @(negedge clk);
            cmd_go = 1'b0;
        end
        chk(beat_vld == 1'b0, "R7", int'(beat_vld), 0);
        chk(burst_done == 1'b1, "R7", int'(burst_done), 1);
        @(negedge clk);

        // R8: cmd_intr replaces a running burst.
        cmd_go = 1'b1; start_col = 8'h12; len_sel = 3'd3; wrap_il = 1'b1;
        @(negedge clk);
        cmd_go = 1'b0;
        for (int k = 0; k < 3; k++) @(negedge clk);
        chk(int'(beat_col) == exp_col(8'h12, 3, 1'b1, 3), "R4", int'(beat_col),
            exp_col(8'h12, 3, 1'b1, 3));
        cmd_intr = 1'b1; start_col = 8'h7E; len_sel = 3'd2; wrap_il = 1'b0; cmd_write = 1'b1;
        @(negedge clk);
        cmd_intr = 1'b0;
        chk(burst_done == 1'b1, "R8", int'(burst_done), 1);
        for (int k = 0; k < 4; k++) begin
            chk(beat_vld == 1'b1, "R8", int'(beat_vld), 1);
            chk(int'(beat_col) == exp_col(8'h7E, 2, 1'b0, k), "R8", int'(beat_col),
                exp_col(8'h7E, 2, 1'b0, k));
            chk(beat_wr == 1'b1, "R10", int'(beat_wr), 1);
            @(negedge clk);
        end
        chk(beat_vld == 1'b0, "R8", int'(beat_vld), 0);
        chk(burst_done == 1'b1, "R8", int'(burst_done), 1);
        @(negedge clk);
        chk(burst_done == 1'b0, "R11", int'(burst_done), 0);

        // Constrained random bursts.
        for (int t = 0; t < 60; t++) begin
            int s  = int'($urandom_range(255, 0));
            int l  = int'($urandom_range(7, 0));
            bit il = 1'($urandom_range(1, 0));
            bit w  = 1'($urandom_range(1, 0));
            int sa;
            if (l > 3)
                sa = int'($urandom_range(299, 0));
            else if ($urandom_range(3, 0) == 0)
                sa = int'($urandom_range((1 << l) - 1, 0));
            else
                sa = -1;
            burst(s, l, il, w, sa);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule